// File: doc/BRIEF.md
# Multiprocessor Wake-Up Sequencer

This block runs on the boot processor's side of a multiprocessor system and brings the other processors out of reset. A single start pulse begins the run. The block first asks the shared check-in counter to load the value 1, which counts the boot processor itself. It then writes three messages into the low word of an interprocessor command register, and each message goes to every processor except the sender. The first message is an INIT. The second and third are identical start-up messages that carry an entry vector.

After each write, the block waits until the command register reports that its message has left. It then runs a fixed delay before going on. The delay after INIT is long, and the delay after each start-up message is short. After the final delay the block samples the shared counter and returns that value together with a one-cycle done pulse. The woken processors begin execution at a 4 KiB page. The page number is the start-up vector, and the block also drives the full entry address as a constant.

Top module: `mp_wake_seq`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `cmd_wr_o` and `cnt_load_o` are 0 and `ap_count_o` is 0.
- R2: When the block is idle, a `start_i` pulse makes `cnt_load_o` high for exactly one cycle in the next cycle, with `cnt_seed_o` equal to 1. `busy_o` rises in that same cycle.
- R3: One run makes exactly three one-cycle writes, in this order: INIT word 0x000C4500, then start-up word 0x000C4600 OR'ed with the vector, twice. The vector defaults to 0x11, which gives 0x000C4611. Field positions: bits 7:0 vector, bits 10:8 delivery mode (101 INIT, 110 start-up), bit 14 level assert = 1, bits 19:18 shorthand 11 (all but self).
- R4: After a write, the block neither writes again nor starts its delay while `cmd_pend_i` (bit 12 of the command low word) reads 1.
- R5: If pending stays high for P cycles after the INIT write, the next write comes exactly INIT_DLY_CYC + P + 3 cycles after the INIT write.
- R6: If pending stays high for P cycles after a start-up write, the next write comes exactly SIPI_DLY_CYC + P + 3 cycles after that write. After the second start-up write, `done_o` comes in that same cycle instead of a write.
- R7: `done_o` is a one-cycle pulse, and `busy_o` is low in that cycle. In that cycle `ap_count_o` holds the value that `cnt_i` had one cycle earlier.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The run is neither restarted nor extended, and no extra counter load or write occurs.
- R9: `entry_addr_o` equals the vector shifted left by 12, which is 0x00011000 for vector 0x11.
- R10: `cmd_wr_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| cmd_wr_o | output | 1 | Write strobe to the command low word |
| cmd_data_o | output | 32 | Command word to write |
| cmd_pend_i | input | 1 | Pending status, bit 12 of the command low word |
| cnt_load_o | output | 1 | Load strobe for the shared check-in counter |
| cnt_seed_o | output | CNT_W | Value to load into the counter (1) |
| cnt_i | input | CNT_W | Shared check-in counter value |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ap_count_o | output | CNT_W | Counter value captured at the end of the run |
| entry_addr_o | output | 32 | Entry address selected by the start-up vector |

## Verification
The bench builds the block with INIT_DLY_CYC = 40 and SIPI_DLY_CYC = 12 in place of the millisecond-scale defaults. This lets a run complete in about a hundred cycles, so many runs fit in a short simulation. Because the two delays differ, a swapped delay shows up as a wrong gap. The default vector 0x11 is kept, so the command words and the entry address are checked against their literal values. Random pending durations from 1 to 8 cycles, plus one run with a 40-cycle pending stall, exercise the polling in every gap.

// File: rtl/mp_wake_pkg.sv
package mp_wake_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_SETTLE,
    S_POLL,
    S_WAIT,
    S_SAMPLE
  } seq_st_e;

  localparam logic [2:0] DM_INIT    = 3'b101;
  localparam logic [2:0] DM_STARTUP = 3'b110;
  localparam logic [1:0] SH_OTHERS  = 2'b11;
  localparam int         LAST_STEP  = 2;

  // assemble a broadcast-to-others, level-assert command low word
  function automatic logic [31:0] ipi_word(input logic [2:0] dm, input logic [7:0] vec);
    logic [31:0] w;
    w        = 32'd0;
    w[19:18] = SH_OTHERS;
    w[14]    = 1'b1;
    w[10:8]  = dm;
    w[7:0]   = vec;
    return w;
  endfunction

endpackage

// File: rtl/mp_wake_timer.sv
module mp_wake_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // countdown stops at zero and steps by one, so each wait is exact
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  p_step_one_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mp_wake_cmd.sv
module mp_wake_cmd
  import mp_wake_pkg::*;
#(
  parameter logic [7:0] VEC = 8'h11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fire_i,
  input  logic        sipi_i,
  output logic        wr_o,
  output logic [31:0] data_o
);

  localparam logic [31:0] W_INIT = ipi_word(DM_INIT, 8'h00);
  localparam logic [31:0] W_SIPI = ipi_word(DM_STARTUP, VEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_o   <= 1'b0;
      data_o <= '0;
    end else begin
      wr_o <= fire_i;
      if (fire_i) data_o <= sipi_i ? W_SIPI : W_INIT;
    end
  end

  p_word_legal_r3: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> (data_o == W_INIT || data_o == W_SIPI));

endmodule

// File: rtl/mp_wake_seq.sv
module mp_wake_seq
  import mp_wake_pkg::*;
#(
  parameter int unsigned INIT_DLY_CYC = 500000,
  parameter int unsigned SIPI_DLY_CYC = 10000,
  parameter logic [7:0]  SIPI_VEC     = 8'h11,
  parameter int unsigned CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             cmd_wr_o,
  output logic [31:0]      cmd_data_o,
  input  logic             cmd_pend_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_seed_o,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] ap_count_o,
  output logic [31:0]      entry_addr_o
);

  localparam int unsigned DLY_MAX = (INIT_DLY_CYC > SIPI_DLY_CYC) ? INIT_DLY_CYC : SIPI_DLY_CYC;
  localparam int unsigned TW      = $clog2(DLY_MAX + 1);
  localparam logic [TW-1:0] LD_INIT = TW'(INIT_DLY_CYC - 1);
  localparam logic [TW-1:0] LD_SIPI = TW'(SIPI_DLY_CYC - 1);

  seq_st_e    st_q;
  logic [1:0] step_q;
  logic       tmr_load, tmr_zero;

  assign tmr_load     = (st_q == S_POLL) && !cmd_pend_i;
  assign cnt_seed_o   = CNT_W'(1);
  assign entry_addr_o = {12'd0, SIPI_VEC, 12'd0};

  mp_wake_cmd #(.VEC(SIPI_VEC)) u_cmd (
    .clk    (clk),
    .rst    (rst),
    .fire_i (st_q == S_SEND),
    .sipi_i (step_q != 2'd0),
    .wr_o   (cmd_wr_o),
    .data_o (cmd_data_o)
  );

  mp_wake_timer #(.TW(TW)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i ((step_q == 2'd0) ? LD_INIT : LD_SIPI),
    .zero_o     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      step_q     <= 2'd0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      cnt_load_o <= 1'b0;
      ap_count_o <= '0;
    end else begin
      cnt_load_o <= 1'b0;
      done_o     <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          busy_o     <= 1'b1;
          cnt_load_o <= 1'b1;
          step_q     <= 2'd0;
          st_q       <= S_SEND;
        end
        S_SEND:   st_q <= S_SETTLE;
        S_SETTLE: st_q <= S_POLL;
        S_POLL:   if (tmr_load) st_q <= S_WAIT;
        S_WAIT: if (tmr_zero) begin
          if (step_q == 2'(LAST_STEP)) st_q <= S_SAMPLE;
          else begin
            step_q <= step_q + 2'd1;
            st_q   <= S_SEND;
          end
        end
        S_SAMPLE: begin
          ap_count_o <= cnt_i;
          done_o     <= 1'b1;
          busy_o     <= 1'b0;
          st_q       <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_seed_busy_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_load_o |-> busy_o);
  p_first_init_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_o && step_q == 2'd0) |-> (cmd_data_o[10:8] == DM_INIT));
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_POLL && cmd_pend_i) |=> (st_q == S_POLL && !cmd_wr_o));
  p_step_max_r6: assert property (@(posedge clk) disable iff (rst)
    step_q <= 2'(LAST_STEP));
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> !cnt_load_o);
  p_wr_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_wr_o |=> !cmd_wr_o);

endmodule

// File: tb/mp_wake_seq_test.sv
module mp_wake_seq_test;

  localparam int unsigned TB_INIT = 40;
  localparam int unsigned TB_SIPI = 12;
  localparam int unsigned CW      = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          cmd_wr_o, cnt_load_o, busy_o, done_o;
  logic [31:0]   cmd_data_o, entry_addr_o;
  logic          pend = 1'b0;
  logic [CW-1:0] cnt_seed_o, ap_count_o;
  logic [CW-1:0] cnt_i = '0;

  int checks = 0, fails = 0, cyc = 0;
  int plist[3];
  int widx = 0, rem = 0;
  int nwr = 0, nload = 0, ndone = 0, pend_viol = 0;
  int wr_t[4];
  logic [31:0] wr_d[4];
  int done_t = 0;
  logic [CW-1:0] done_cnt;
  logic done_busy;

  always #10 clk = ~clk;  // 50 MHz

  mp_wake_seq #(.INIT_DLY_CYC(TB_INIT), .SIPI_DLY_CYC(TB_SIPI), .SIPI_VEC(8'h11), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .cmd_wr_o(cmd_wr_o), .cmd_data_o(cmd_data_o), .cmd_pend_i(pend),
    .cnt_load_o(cnt_load_o), .cnt_seed_o(cnt_seed_o), .cnt_i(cnt_i),
    .busy_o(busy_o), .done_o(done_o), .ap_count_o(ap_count_o),
    .entry_addr_o(entry_addr_o)
  );

  // command register model: pending stays high for plist[] cycles after each write
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) pend <= 1'b0;
    else if (cmd_wr_o) begin
      pend <= 1'b1;
      rem  <= plist[widx % 3] - 1;
      widx <= widx + 1;
    end else if (pend) begin
      if (rem == 0) pend <= 1'b0;
      else rem <= rem - 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_wr_o) begin
        if (nwr < 4) begin wr_t[nwr] = cyc; wr_d[nwr] = cmd_data_o; end
        nwr++;
        if (pend) pend_viol++;
      end
      if (cnt_load_o) nload++;
      if (done_o) begin
        done_t = cyc; ndone++; done_cnt = ap_count_o; done_busy = busy_o;
      end
    end
  end

  function automatic int exp_gap(input int p, input int w);
    return w + p + 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input int pa, input int pb, input int pc, input bit stray);
    int g;
    plist[0] = pa; plist[1] = pb; plist[2] = pc;
    widx = 0; nwr = 0; nload = 0; ndone = 0; pend_viol = 0;
    cnt_i = CW'($urandom_range(2, 255));
    @(negedge clk); #1 start_i = 1'b1;
    @(negedge clk); #1 start_i = 1'b0;
    check(cnt_load_o == 1'b1 && busy_o == 1'b1, "R2 load+busy", {cnt_load_o, busy_o}, 3);
    check(cnt_seed_o == 1, "R2 seed", cnt_seed_o, 1);
    if (stray) begin
      repeat (5) @(negedge clk);
      #1 start_i = 1'b1;
      @(negedge clk); #1 start_i = 1'b0;
    end
    g = 0;
    while (ndone == 0 && g < 3000) begin
      @(negedge clk); #1 g++;
    end
    repeat (4) @(negedge clk);
    #1;
    check(ndone == 1, "R7 one done", ndone, 1);
    check(nwr == 3, "R3/R8 write count", nwr, 3);
    check(nload == 1, "R8 single load", nload, 1);
    check(wr_d[0] == 32'h000C4500, "R3 INIT word", wr_d[0], 32'h000C4500);
    check(wr_d[1] == 32'h000C4611, "R3 SIPI word 1", wr_d[1], 32'h000C4611);
    check(wr_d[2] == 32'h000C4611, "R3 SIPI word 2", wr_d[2], 32'h000C4611);
    check(wr_t[1] - wr_t[0] == exp_gap(pa, TB_INIT), "R5 INIT gap", wr_t[1] - wr_t[0], exp_gap(pa, TB_INIT));
    check(wr_t[2] - wr_t[1] == exp_gap(pb, TB_SIPI), "R6 SIPI gap", wr_t[2] - wr_t[1], exp_gap(pb, TB_SIPI));
    check(done_t - wr_t[2] == exp_gap(pc, TB_SIPI), "R6 final gap", done_t - wr_t[2], exp_gap(pc, TB_SIPI));
    check(done_cnt == cnt_i, "R7 count", done_cnt, cnt_i);
    check(done_busy == 1'b0 && busy_o == 1'b0, "R7 busy low", {done_busy, busy_o}, 0);
    check(pend_viol == 0, "R4 write under pending", pend_viol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    check(busy_o == 0 && done_o == 0 && cmd_wr_o == 0 && cnt_load_o == 0, "R1 reset outputs",
          {busy_o, done_o, cmd_wr_o, cnt_load_o}, 0);
    check(ap_count_o == 0, "R1 reset count", ap_count_o, 0);
    rst = 1'b0;
    check(entry_addr_o == 32'h00011000, "R9 entry address", entry_addr_o, 32'h00011000);
    run_seq(1, 1, 1, 1'b0);
    run_seq(40, 2, 3, 1'b0);
    run_seq(3, 5, 2, 1'b1);
    for (int i = 0; i < 6; i++)
      run_seq($urandom_range(1, 8), $urandom_range(1, 8), $urandom_range(1, 8), i[0]);
    check(busy_o == 0, "R8 idle after stray starts", busy_o, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule